// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frames into host memory by walking a ring of receive descriptors. Each descriptor occupies four consecutive 32-bit words. The engine fetches the status word and proceeds only when the ownership flag grants it the descriptor. It then reads the buffer size, the buffer pointer and the link word. Bytes from a framed byte stream are packed into words and stored in the buffer. When the frame ends, the engine writes a completion status word that gives the descriptor back to the host.

When the engine meets a descriptor that the host still owns, it parks. It resumes only on a poll-demand pulse. The next descriptor can come from the link word, from the ring base, or from the next consecutive slot. Frames never span buffers: bytes beyond the buffer size are dropped and the frame is flagged as an error. Memory is reached through a single request/acknowledge word port with one access outstanding at a time. All addresses are word addresses.

Top module: `rxr_dma`

## Requirements
- R1: A descriptor at word address D is read as D+0 status, D+1 control, D+2 buffer word address, D+3 link word, in that order, before any byte of a frame is accepted.
- R2: If status bit 31 is 0 when read, `suspended` goes high and the engine makes no memory request and accepts no byte. While enabled, a `poll_demand` pulse clears `suspended` on the next cycle and re-reads the status word. Writing ownership alone does not resume the engine.
- R3: Stored bytes go into consecutive buffer words, four per word, with the first byte in bits 7:0. Unused bytes of a final partial word are zero. No word beyond ceil(stored/4) is written.
- R4: On completion the status word has bit 31 = 0, bit 30 = 1 and bit 8 = 1. Bits 29:16 hold the count of every byte from the start mark to the end mark, FCS included. Bit 15 is the error flag, and all other bits are 0.
- R5: Bytes past the buffer size (control bits 10:0) are discarded. The error flag (status bit 15) is set, and the descriptor is still returned with the full length.
- R6: The next descriptor is the link word when control bit 24 is set. Otherwise it is the ring base when bit 25 is set, and otherwise D+4.
- R7: While the engine waits for a frame, bytes without a start mark are consumed and dropped.
- R8: With `rx_enable` low, a waiting engine accepts no byte and issues no request, and its next descriptor is the ring base. Lowering `rx_enable` inside a frame still lets that frame complete and return its descriptor.
- R9: `mem_req` with its address and direction stays stable until `mem_ack`. `s_ready` is never high together with `mem_req`.
- R10: After reset `mem_req`, `s_ready` and `suspended` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_enable | input | 1 | Engine enable |
| ring_base | input | AW | Word address of the first descriptor |
| poll_demand | input | 1 | Restart pulse for a suspended engine |
| suspended | output | 1 | Engine parked on a host-owned descriptor |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_sof | input | 1 | First byte of a frame |
| s_eof | input | 1 | Last byte of a frame |
| s_ready | output | 1 | Stream byte accepted this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |

## Verification
The bench builds the engine with AW = 8 and little-endian lane order over a 256-word memory. This puts three descriptors, their buffers and every next-address rule within one small map. One descriptor has a 6-byte buffer, so a sweep of frame lengths crosses both the word boundaries and the truncation edge at 6/7 bytes, and a 64-byte buffer is tested at 64 and 65 bytes. Every frame is checked word by word against arithmetic expectations, including a sentinel just past the written area.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   localparam int WORD_W    = 32;
   localparam int OWN_BIT   = 31;
   localparam int FIRST_BIT = 30;
   localparam int LAST_BIT  = 8;
   localparam int ERR_BIT   = 15;
   localparam int LEN_LSB   = 16;
   localparam int LEN_W     = 14;
   localparam int SIZE_W    = 11;
   localparam int CHAIN_BIT = 24;
   localparam int EOR_BIT   = 25;

   typedef enum logic [3:0] {
      ST_IDLE, ST_RD_STAT, ST_SUSP, ST_RD_CTL, ST_RD_BUF, ST_RD_LINK,
      ST_WAIT_SOF, ST_FILL, ST_WR_DATA, ST_WR_STAT
   } rxr_state_e;
endpackage

// File: rtl/rxr_lane_pack.sv
module rxr_lane_pack #(
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic [31:0] word_in,
   input  logic [1:0]  lane,
   input  logic [7:0]  byte_in,
   output logic [31:0] word_out
);
   logic [4:0]  shamt;
   logic [31:0] wide;

   assign wide = {24'd0, byte_in};

   generate
      if (LSB_FIRST) begin : g_lsb
         assign shamt = {lane, 3'b000};
      end else begin : g_msb
         assign shamt = {~lane, 3'b000};
      end
   endgenerate

   assign word_out = word_in | (wide << shamt);
endmodule

// File: rtl/rxr_stat_pack.sv
module rxr_stat_pack (
   input  logic [rxr_pkg::LEN_W-1:0] frame_len,
   input  logic                      err,
   output logic [31:0]               word
);
   import rxr_pkg::*;
   always_comb begin
      word = '0;
      word[FIRST_BIT] = 1'b1;
      word[LAST_BIT]  = 1'b1;
      word[ERR_BIT]   = err;
      word[LEN_LSB +: LEN_W] = frame_len;
   end
endmodule

// File: rtl/rxr_next_sel.sv
module rxr_next_sel #(
   parameter int AW = 16
) (
   input  logic [AW-1:0] cur,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] link,
   input  logic          chain,
   input  logic          eor,
   output logic [AW-1:0] next
);
   localparam logic [AW-1:0] STRIDE = AW'(4);
   always_comb begin
      if (chain)    next = link;
      else if (eor) next = base;
      else          next = cur + STRIDE;
   end
endmodule

// File: rtl/rxr_dma.sv
module rxr_dma #(
   parameter int AW        = 16,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_enable,
   input  logic [AW-1:0] ring_base,
   input  logic          poll_demand,
   output logic          suspended,
   input  logic          s_valid,
   input  logic [7:0]    s_data,
   input  logic          s_sof,
   input  logic          s_eof,
   output logic          s_ready,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic [31:0]   mem_rdata,
   input  logic          mem_ack
);
   import rxr_pkg::*;

   localparam logic [LEN_W-1:0] LEN_MAX = '1;

   generate
      if (AW < 4 || AW > 32) begin : g_bad_aw
         $error("rxr_dma: AW must lie in 4..32");
      end
   endgenerate

   rxr_state_e        st;
   logic [AW-1:0]     cur, link, buf_ptr, next_desc;
   logic [SIZE_W-1:0] size;
   logic              chain, eor, err, eof_seen;
   logic [LEN_W-1:0]  len;
   logic [2:0]        cnt;
   logic [31:0]       wbuf, wbuf_nx, stat_word;
   logic              take, store;
   logic              unused_rd;

   assign unused_rd = ^mem_rdata;

   rxr_lane_pack #(.LSB_FIRST(LSB_FIRST)) u_pack (
      .word_in(wbuf), .lane(cnt[1:0]), .byte_in(s_data), .word_out(wbuf_nx));

   rxr_stat_pack u_stat (.frame_len(len), .err(err), .word(stat_word));

   rxr_next_sel #(.AW(AW)) u_next (
      .cur(cur), .base(ring_base), .link(link), .chain(chain), .eor(eor),
      .next(next_desc));

   always_comb begin
      mem_req = 1'b0;
      mem_we  = 1'b0;
      mem_addr = cur;
      mem_wdata = wbuf;
      case (st)
         ST_RD_STAT: mem_req = 1'b1;
         ST_RD_CTL:  begin mem_req = 1'b1; mem_addr = cur + AW'(1); end
         ST_RD_BUF:  begin mem_req = 1'b1; mem_addr = cur + AW'(2); end
         ST_RD_LINK: begin mem_req = 1'b1; mem_addr = cur + AW'(3); end
         ST_WR_DATA: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = buf_ptr; end
         ST_WR_STAT: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = stat_word; end
         default: ;
      endcase
   end

   assign suspended = (st == ST_SUSP);
   assign s_ready   = (st == ST_FILL) || (st == ST_WAIT_SOF && rx_enable);
   assign take      = s_valid && s_ready && (st == ST_FILL || s_sof);
   assign store     = len < LEN_W'(size);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE;
         cur <= '0; link <= '0; buf_ptr <= '0; size <= '0;
         chain <= 1'b0; eor <= 1'b0; err <= 1'b0; eof_seen <= 1'b0;
         len <= '0; cnt <= '0; wbuf <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               cur <= ring_base;
               if (rx_enable) st <= ST_RD_STAT;
            end
            ST_RD_STAT: if (mem_ack) st <= mem_rdata[OWN_BIT] ? ST_RD_CTL : ST_SUSP;
            ST_SUSP: begin
               if (!rx_enable)       st <= ST_IDLE;
               else if (poll_demand) st <= ST_RD_STAT;
            end
            ST_RD_CTL: if (mem_ack) begin
               size  <= mem_rdata[SIZE_W-1:0];
               chain <= mem_rdata[CHAIN_BIT];
               eor   <= mem_rdata[EOR_BIT];
               st    <= ST_RD_BUF;
            end
            ST_RD_BUF: if (mem_ack) begin
               buf_ptr <= mem_rdata[AW-1:0];
               st      <= ST_RD_LINK;
            end
            ST_RD_LINK: if (mem_ack) begin
               link <= mem_rdata[AW-1:0];
               st   <= ST_WAIT_SOF;
            end
            ST_WAIT_SOF, ST_FILL: begin
               if (st == ST_WAIT_SOF && !rx_enable) begin
                  st <= ST_IDLE;
               end else if (take) begin
                  st <= ST_FILL;
                  if (store) begin
                     wbuf <= wbuf_nx;
                     cnt  <= cnt + 3'd1;
                  end else begin
                     err <= 1'b1;
                  end
                  if (len != LEN_MAX) len <= len + 1'b1;
                  if (s_eof) begin
                     eof_seen <= 1'b1;
                     st <= (store || cnt != 3'd0) ? ST_WR_DATA : ST_WR_STAT;
                  end else if (store && cnt == 3'd3) begin
                     st <= ST_WR_DATA;
                  end
               end
            end
            ST_WR_DATA: if (mem_ack) begin
               buf_ptr <= buf_ptr + AW'(1);
               cnt  <= '0;
               wbuf <= '0;
               st   <= eof_seen ? ST_WR_STAT : ST_FILL;
            end
            ST_WR_STAT: if (mem_ack) begin
               cur <= next_desc;
               len <= '0; cnt <= '0; wbuf <= '0;
               err <= 1'b0; eof_seen <= 1'b0;
               st  <= rx_enable ? ST_RD_STAT : ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
   parameter int AW = 16
) (
   input logic                clk,
   input logic                rst_n,
   input rxr_pkg::rxr_state_e st,
   input logic                rx_enable,
   input logic                poll_demand,
   input logic                suspended,
   input logic                s_ready,
   input logic                mem_req,
   input logic                mem_we,
   input logic [AW-1:0]       mem_addr,
   input logic [31:0]         mem_wdata,
   input logic                mem_ack
);
   import rxr_pkg::*;

   assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   assert_req_ready_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req && s_ready));

   assert_suspend_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      suspended |-> (!mem_req && !s_ready));

   assert_poll_resume_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (suspended && poll_demand && rx_enable) |=> (!suspended && mem_req && !mem_we));

   assert_status_marks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WR_STAT && mem_req) |->
         (!mem_wdata[OWN_BIT] && mem_wdata[FIRST_BIT] && mem_wdata[LAST_BIT]));
endmodule

bind rxr_dma rxr_checker #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .st(st), .rx_enable(rx_enable),
   .poll_demand(poll_demand), .suspended(suspended), .s_ready(s_ready),
   .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
   .mem_wdata(mem_wdata), .mem_ack(mem_ack));

// File: tb/tb_rxr_dma.sv
module tb_rxr_dma;
   localparam int CLK_P = 10;
   localparam int AW    = 8;
   localparam int BASE  = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_enable = 1'b0;
   logic [AW-1:0] ring_base = AW'(BASE);
   logic          poll_demand = 1'b0;
   logic          suspended;
   logic          s_valid = 1'b0, s_sof = 1'b0, s_eof = 1'b0;
   logic [7:0]    s_data = '0;
   logic          s_ready;
   logic          mem_req, mem_we, mem_ack;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_wdata, mem_rdata;

   logic          hw_en = 1'b0;
   logic [AW-1:0] hw_addr = '0;
   logic [31:0]   hw_data = '0;
   logic [31:0]   mem [0:255];

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   rxr_dma #(.AW(AW), .LSB_FIRST(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .ring_base(ring_base),
      .poll_demand(poll_demand), .suspended(suspended),
      .s_valid(s_valid), .s_data(s_data), .s_sof(s_sof), .s_eof(s_eof),
      .s_ready(s_ready), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ack(mem_ack));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_ack   <= 1'b0;
         mem_rdata <= '0;
      end else begin
         mem_ack <= mem_req && !mem_ack;
         if (mem_req && !mem_ack) begin
            mem_rdata <= mem[mem_addr];
            if (mem_we) mem[mem_addr] <= mem_wdata;
         end
         if (hw_en) mem[hw_addr] <= hw_data;
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic hw(input int a, input logic [31:0] d);
      @(negedge clk);
      hw_en = 1'b1; hw_addr = AW'(a); hw_data = d;
      @(negedge clk);
      hw_en = 1'b0;
   endtask

   function automatic int d_addr(input int i);
      return (i == 0) ? 16 : (i == 1) ? 20 : 40;
   endfunction
   function automatic int d_buf(input int i);
      return (i == 0) ? 100 : (i == 1) ? 140 : 180;
   endfunction
   function automatic int d_size(input int i);
      return (i == 2) ? 6 : 64;
   endfunction

   task automatic fill_sentinel(input int i);
      for (int w = 0; w < 18; w++) hw(d_buf(i) + w, 32'hDEADBEEF);
   endtask

   task automatic put_byte(input logic [7:0] d, input bit sof, input bit eof);
      int n;
      @(negedge clk);
      s_valid = 1'b1; s_data = d; s_sof = sof; s_eof = eof;
      n = 0;
      while (!s_ready && n < 2000) begin
         @(negedge clk);
         n++;
      end
      if (n >= 2000) chk(1'b0, "stream stall", 0, 1);
      @(posedge clk);
   endtask

   task automatic stream_idle();
      @(negedge clk);
      s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
   endtask

   task automatic send_frame(input int len, input int seed, input int drop_at);
      for (int i = 0; i < len; i++) begin
         if (i == drop_at) rx_enable = 1'b0;
         put_byte(8'(seed + i), i == 0, i == len - 1);
      end
      stream_idle();
   endtask

   task automatic wait_done(input int a);
      int n = 0;
      while (mem[a][31] && n < 3000) begin
         @(negedge clk);
         n++;
      end
      chk(!mem[a][31], "R2/R6 descriptor completion", n, 0);
   endtask

   task automatic check_frame(input int i, input int len, input int seed);
      int stored, nw;
      logic [31:0] exp_st, exp_w;
      bit trunc;
      trunc  = len > d_size(i);
      stored = trunc ? d_size(i) : len;
      nw     = (stored + 3) / 4;
      exp_st = (32'd1 << 30) | (32'd1 << 8) | (32'(len) << 16) | (32'(trunc) << 15);
      chk(mem[d_addr(i)] == exp_st, trunc ? "R5 truncated status" : "R4 status word",
          mem[d_addr(i)], exp_st);
      for (int w = 0; w < nw; w++) begin
         exp_w = '0;
         for (int b = 0; b < 4; b++)
            if (w * 4 + b < stored) exp_w[b*8 +: 8] = 8'(seed + w * 4 + b);
         chk(mem[d_buf(i) + w] == exp_w, "R3 buffer word", mem[d_buf(i) + w], exp_w);
      end
      chk(mem[d_buf(i) + nw] == 32'hDEADBEEF, "R3 R5 no overrun",
          mem[d_buf(i) + nw], 32'hDEADBEEF);
   endtask

   task automatic rearm(input int i);
      fill_sentinel(i);
      hw(d_addr(i), 32'h8000_0000);
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int idx, len, seed;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!mem_req && !s_ready && !suspended, "R10 reset outputs",
          {mem_req, s_ready, suspended}, 0);

      // ring: D0 plain -> D1 (R6 +4), D1 chained -> 40, D2 end-of-ring -> base
      hw(17, 32'd64);                     hw(18, 32'd100); hw(19, 32'd77);
      hw(21, (32'd1 << 24) | 32'd64);     hw(22, 32'd140); hw(23, 32'd40);
      hw(41, (32'd1 << 25) | 32'd6);      hw(42, 32'd180); hw(43, 32'd99);
      for (int i = 0; i < 3; i++) fill_sentinel(i);
      hw(16, 32'h0);
      hw(20, 32'h8000_0000);
      hw(40, 32'h8000_0000);

      rx_enable = 1'b1;
      repeat (30) @(negedge clk);
      chk(suspended && !mem_req, "R2 suspend on host-owned", {suspended, mem_req}, 2'b10);
      hw(16, 32'h8000_0000);
      repeat (20) @(negedge clk);
      chk(suspended, "R2 no resume without poll", suspended, 1);
      poll_demand = 1'b1;
      @(negedge clk);
      poll_demand = 1'b0;
      chk(!suspended && mem_req, "R2 resume on poll R1 reread", {suspended, mem_req}, 2'b01);

      idx = 0;
      for (int k = 0; k < 13; k++) begin
         if (idx == 2) len = 5 + k / 3;
         else if (k == 9) len = 64;
         else if (k == 10) len = 65;
         else len = 1 + (k * 5) % 17;
         seed = k * 16 + 3;
         if (k == 4) begin
            // R7: unmarked bytes before a frame are dropped
            put_byte(8'hA5, 1'b0, 1'b0);
            put_byte(8'h5A, 1'b0, 1'b0);
            put_byte(8'h3C, 1'b0, 1'b1);
         end
         send_frame(len, seed, -1);
         wait_done(d_addr(idx));
         check_frame(idx, len, seed);
         rearm(idx);
         idx = (idx + 1) % 3;   // R6 order D0 -> D1 -> D2 -> D0
      end

      // R8: disabled while waiting on D1
      rx_enable = 1'b0;
      repeat (5) @(negedge clk);
      s_valid = 1'b1; s_sof = 1'b1; s_eof = 1'b0; s_data = 8'h11;
      for (int c = 0; c < 10; c++) begin
         @(negedge clk);
         chk(!s_ready && !mem_req && !suspended, "R8 idle when disabled",
             {s_ready, mem_req, suspended}, 0);
      end
      stream_idle();
      rx_enable = 1'b1;
      send_frame(9, 200, -1);
      wait_done(d_addr(0));
      check_frame(0, 9, 200);          // R8 restart at ring base
      chk(mem[d_addr(1)][31], "R8 D1 untouched", mem[d_addr(1)][31], 1);
      rearm(0);

      // R8: disable inside a frame, frame still completes on D1
      send_frame(5, 50, 2);
      wait_done(d_addr(1));
      check_frame(1, 5, 50);
      for (int c = 0; c < 10; c++) begin
         @(negedge clk);
         chk(!mem_req && !s_ready, "R8 stop after frame", {mem_req, s_ready}, 0);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule